// File: doc/BRIEF.md
# Two-Lane Estimate Exception and Writeback Gate

This block sits beside the arithmetic of a two-lane single-precision estimate operation, such as a reciprocal or reciprocal square root estimate. It does not compute estimates. Each cycle that `in_valid` is high, it looks at both 64-bit double-format source operands. It folds the exceptional conditions it finds into the floating-point status flags supplied by the caller, and returns the updated flags in the same cycle.

From the same inspection it decides whether the destination register pair may take the lane estimates, which arrive on `estimates`. Conditions are detected lane by lane. Writeback, however, is all or nothing. A lane vetoes the write only when the exception it raises is enabled. The result-class field follows lane 0 alone. One cycle after the strobe, the block pulses `wr_en` with the registered estimates. It also pulses `cls_we`, with lane 0's estimate as the source for the class field.

Top module: `pe_pair_gate`

## Requirements
- R1: A lane operand is a signalling NaN when bits 62:52 are all ones, bits 51:0 are non-zero, and bit 51 is clear. On a valid cycle, flag bit 0 (signalling-NaN invalid) is the input bit 0 ORed with the signalling-NaN result of either lane.
- R2: A lane operand is zero when bits 62:0 are all zero, with either sign. On a valid cycle, flag bit 2 (zero divide) is the input bit 2 ORed with the zero result of either lane.
- R3: When `sqrt_mode` is high, a lane raises square-root invalid if bit 63 is set, the operand is not zero, and it is not a signalling NaN. On a valid cycle, flag bit 1 is the input bit 1 ORed with this condition from either lane. When `sqrt_mode` is low, flag bit 1 is unchanged.
- R4: A lane blocks writeback when it raises signalling-NaN or square-root invalid while `inv_en` is high, or when it is zero while `zdiv_en` is high. A condition whose enable is low never blocks.
- R5: In the cycle after a valid cycle in which no lane blocks, `wr_en` is high for one cycle and `wr_data` carries both lane estimates, with lane 0 in the low 64 bits. Otherwise `wr_en` is low, so either both lanes are written or neither is.
- R6: In the cycle after a valid cycle in which lane 0 does not block, `cls_we` is high and `cls_src` holds lane 0's estimate. Whether lane 1 blocks has no effect on `cls_we`.
- R7: On a valid cycle, flag bit 3 (fraction inexact) equals `inexact`. Flag bit 4 (sticky inexact) always equals its input value.
- R8: When `in_valid` is low, `flags_out` equals `flags_in`, and `wr_en` and `cls_we` are low in the next cycle.
- R9: Flag bits 0, 1, 2 and 4 are never cleared by the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| sqrt_mode | input | 1 | Operation is a reciprocal square root estimate |
| inv_en | input | 1 | Invalid-operation exception enabled |
| zdiv_en | input | 1 | Zero-divide exception enabled |
| inexact | input | 1 | Estimate rounding was inexact |
| operands | input | 128 | Source operands, lane 0 in bits 63:0 |
| estimates | input | 128 | Lane estimates, lane 0 in bits 63:0 |
| flags_in | input | 5 | Current status flags |
| flags_out | output | 5 | Updated status flags, same cycle |
| wr_en | output | 1 | Destination pair write pulse |
| wr_data | output | 128 | Registered estimates for the write |
| cls_we | output | 1 | Result-class update pulse |
| cls_src | output | 64 | Lane 0 estimate for the class update |

## Verification
The bench aims at the edges of the classifier. A quiet NaN has bit 51 set; a gate that treated it as signalling would raise bit 0 and wrongly block the write. A signalling NaN with the sign set must not count as negative, or bit 1 would rise as well. Negative zero counts as zero and not as negative, and a mix-up there shifts the flag between bits 1 and 2. The bench also covers mixed cases: lane 1 alone blocked, where a design that gated lanes separately would pulse `wr_en` or drop `cls_we`, and disabled exceptions, which must still set flags while letting the write through. Idle cycles carry arbitrary flags and an active `inexact`; a design that skipped the valid qualification would alter the flags or pulse the outputs.

// File: rtl/pe_gate_pkg.sv
package pe_gate_pkg;
   localparam int FLAG_W = 5;

   typedef struct packed {
      logic inx_sticky;   // bit 4
      logic frac_inx;     // bit 3
      logic zdiv;         // bit 2
      logic sqrt_inv;     // bit 1
      logic snan_inv;     // bit 0
   } flags_t;
endpackage

// File: rtl/pe_lane_class.sv
module pe_lane_class #(
   parameter int EXP_W        = 11,
   parameter int FRAC_W       = 52,
   parameter bit SQRT_SUPPORT = 1'b1,
   localparam int DW          = 1 + EXP_W + FRAC_W
) (
   input  logic [DW-1:0] opnd,
   input  logic          sqrt_mode,
   input  logic          inv_en,
   input  logic          zdiv_en,
   output logic          is_snan,
   output logic          is_zero,
   output logic          is_sqrt_inv,
   output logic          blocks
);
   logic              sgn;
   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;

   assign sgn = opnd[DW-1];
   assign ex  = opnd[DW-2 -: EXP_W];
   assign fr  = opnd[FRAC_W-1:0];

   always_comb begin
      is_snan = (&ex) && (|fr) && !fr[FRAC_W-1];
      is_zero = (ex == '0) && (fr == '0);
   end

   generate
      if (SQRT_SUPPORT) begin : g_sqrt
         assign is_sqrt_inv = sqrt_mode && sgn && !is_zero && !is_snan;
      end else begin : g_nosqrt
         logic unused_mode;
         assign unused_mode = sqrt_mode ^ sgn;
         assign is_sqrt_inv = 1'b0;
      end
   endgenerate

   assign blocks = ((is_snan || is_sqrt_inv) && inv_en) || (is_zero && zdiv_en);
endmodule

// File: rtl/pe_flag_merge.sv
module pe_flag_merge
   import pe_gate_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             valid,
   input  logic             inexact,
   input  flags_t           cur,
   input  logic [LANES-1:0] snan,
   input  logic [LANES-1:0] zero,
   input  logic [LANES-1:0] sqinv,
   output flags_t           nxt
);
   always_comb begin
      nxt = cur;
      if (valid) begin
         nxt.snan_inv = cur.snan_inv | (|snan);
         nxt.sqrt_inv = cur.sqrt_inv | (|sqinv);
         nxt.zdiv     = cur.zdiv | (|zero);
         nxt.frac_inx = inexact;
      end
   end
endmodule

// File: rtl/pe_pair_gate.sv
module pe_pair_gate
   import pe_gate_pkg::*;
#(
   parameter int EXP_W        = 11,
   parameter int FRAC_W       = 52,
   parameter int LANES        = 2,
   parameter bit SQRT_SUPPORT = 1'b1,
   localparam int DW          = 1 + EXP_W + FRAC_W,
   localparam int PW          = LANES * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              sqrt_mode,
   input  logic              inv_en,
   input  logic              zdiv_en,
   input  logic              inexact,
   input  logic [PW-1:0]     operands,
   input  logic [PW-1:0]     estimates,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out,
   output logic              wr_en,
   output logic [PW-1:0]     wr_data,
   output logic              cls_we,
   output logic [DW-1:0]     cls_src
);
   initial begin
      assert (LANES >= 1) else $error("pe_pair_gate: LANES must be at least 1");
      assert (EXP_W >= 2 && FRAC_W >= 2) else $error("pe_pair_gate: field widths too small");
   end

   logic [LANES-1:0] snan_v, zero_v, sqinv_v, blk_v;
   flags_t           fl_cur, fl_nxt;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         pe_lane_class #(
            .EXP_W       (EXP_W),
            .FRAC_W      (FRAC_W),
            .SQRT_SUPPORT(SQRT_SUPPORT)
         ) u_cls (
            .opnd       (operands[g*DW +: DW]),
            .sqrt_mode  (sqrt_mode),
            .inv_en     (inv_en),
            .zdiv_en    (zdiv_en),
            .is_snan    (snan_v[g]),
            .is_zero    (zero_v[g]),
            .is_sqrt_inv(sqinv_v[g]),
            .blocks     (blk_v[g])
         );
      end
   endgenerate

   assign fl_cur = flags_t'(flags_in);

   pe_flag_merge #(.LANES(LANES)) u_merge (
      .valid  (in_valid),
      .inexact(inexact),
      .cur    (fl_cur),
      .snan   (snan_v),
      .zero   (zero_v),
      .sqinv  (sqinv_v),
      .nxt    (fl_nxt)
   );

   assign flags_out = fl_nxt;

   logic pair_ok, lead_ok;
   assign pair_ok = in_valid && (blk_v == '0);
   assign lead_ok = in_valid && !blk_v[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         cls_we  <= 1'b0;
         wr_data <= '0;
         cls_src <= '0;
      end else begin
         wr_en  <= pair_ok;
         cls_we <= lead_ok;
         if (pair_ok) wr_data <= estimates;
         if (lead_ok) cls_src <= estimates[DW-1:0];
      end
   end
endmodule

// File: rtl/pe_pair_gate_chk.sv
module pe_pair_gate_chk
   import pe_gate_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              inexact,
   input logic [FLAG_W-1:0] flags_in,
   input logic [FLAG_W-1:0] flags_out,
   input logic              wr_en,
   input logic              cls_we
);
   localparam logic [FLAG_W-1:0] STICKY = 5'b10111;

   a_r5_wr_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(in_valid));

   a_r6_cls_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cls_we |-> $past(in_valid));

   a_r6_write_has_class: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> cls_we);

   a_r9_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_in & ~flags_out & STICKY) == '0));

   a_r7_inx_pass: assert property (@(posedge clk) disable iff (!rst_n)
      flags_out[4] == flags_in[4]);

   a_r7_fi_set: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && inexact) |-> flags_out[3]);

   a_r8_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (flags_out == flags_in));
endmodule

bind pe_pair_gate pe_pair_gate_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .inexact  (inexact),
   .flags_in (flags_in),
   .flags_out(flags_out),
   .wr_en    (wr_en),
   .cls_we   (cls_we)
);

// File: tb/pe_pair_gate_tb.sv
module pe_pair_gate_tb;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid, sqrt_mode, inv_en, zdiv_en, inexact;
   logic [127:0] operands, estimates, wr_data;
   logic [4:0]   flags_in, flags_out;
   logic         wr_en, cls_we;
   logic [63:0]  cls_src;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   bit           pend_wr, pend_cls;
   logic [127:0] pend_data;
   logic [63:0]  pend_src;

   always #4 clk = ~clk;

   pe_pair_gate u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sqrt_mode(sqrt_mode),
      .inv_en(inv_en), .zdiv_en(zdiv_en), .inexact(inexact),
      .operands(operands), .estimates(estimates), .flags_in(flags_in),
      .flags_out(flags_out), .wr_en(wr_en), .wr_data(wr_data),
      .cls_we(cls_we), .cls_src(cls_src)
   );

   localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
   localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
   localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
   localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
   localparam logic [63:0] N_SNAN = 64'hFFF4_0000_0000_0000;
   localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] N_QNAN = 64'hFFF8_0000_0000_0001;
   localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] N_DEN  = 64'h8000_0000_0000_0001;

   function automatic bit m_snan(logic [63:0] x);
      return (x[62:52] == 11'h7FF) && (x[51:0] != 0) && (x[51] == 1'b0);
   endfunction
   function automatic bit m_zero(logic [63:0] x);
      return x[62:0] == 0;
   endfunction
   function automatic bit m_neg(logic [63:0] x);
      return x[63] && !m_zero(x) && !m_snan(x);
   endfunction

   task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic chk_regs();
      chk("R5 wr_en", 128'(wr_en), 128'(pend_wr));
      if (pend_wr) chk("R5 wr_data", wr_data, pend_data);
      chk("R6 cls_we", 128'(cls_we), 128'(pend_cls));
      if (pend_cls) chk("R6 cls_src", 128'(cls_src), 128'(pend_src));
   endtask

   task automatic cycle(bit v, bit sq, logic [63:0] a0, logic [63:0] a1,
                        bit ie, bit ze, bit inx, logic [4:0] fin);
      bit sn0, sn1, zr0, zr1, ng0, ng1, blk0, blk1;
      logic [4:0] ef;
      logic [127:0] est;
      @(negedge clk);
      chk_regs();
      est = {$urandom, $urandom, $urandom, $urandom};
      in_valid = v; sqrt_mode = sq; inv_en = ie; zdiv_en = ze; inexact = inx;
      operands = {a1, a0}; estimates = est; flags_in = fin;
      #1;
      sn0 = m_snan(a0); sn1 = m_snan(a1);
      zr0 = m_zero(a0); zr1 = m_zero(a1);
      ng0 = sq && m_neg(a0); ng1 = sq && m_neg(a1);
      blk0 = ((sn0 || ng0) && ie) || (zr0 && ze);
      blk1 = ((sn1 || ng1) && ie) || (zr1 && ze);
      ef = fin;
      if (v) begin
         ef[0] = fin[0] | sn0 | sn1;
         ef[1] = fin[1] | ng0 | ng1;
         ef[2] = fin[2] | zr0 | zr1;
         ef[3] = inx;
      end
      chk(v ? "R1 snan flag" : "R8 idle bit0", 128'(flags_out[0]), 128'(ef[0]));
      chk(v ? "R3 sqrt flag" : "R8 idle bit1", 128'(flags_out[1]), 128'(ef[1]));
      chk(v ? "R2 zdiv flag" : "R8 idle bit2", 128'(flags_out[2]), 128'(ef[2]));
      chk(v ? "R7 frac inexact" : "R8 idle bit3", 128'(flags_out[3]), 128'(ef[3]));
      chk("R7 sticky inexact", 128'(flags_out[4]), 128'(ef[4]));
      chk("R9 sticky kept", 128'(flags_in & ~flags_out & 5'b10111), 128'(0));
      pend_wr   = v && !blk0 && !blk1;   // R4: both lanes gate together
      pend_cls  = v && !blk0;
      pend_data = est;
      pend_src  = est[63:0];
   endtask

   function automatic logic [63:0] pick(int k);
      case (k % 10)
         0: return P_ONE;   1: return N_TWO;  2: return P_ZERO; 3: return N_ZERO;
         4: return SNAN;    5: return N_SNAN; 6: return QNAN;   7: return N_QNAN;
         8: return P_INF;   default: return N_DEN;
      endcase
   endfunction

   initial begin
      rst_n = 1'b0; in_valid = 0; sqrt_mode = 0; inv_en = 0; zdiv_en = 0;
      inexact = 0; operands = '0; estimates = '0; flags_in = '0;
      pend_wr = 0; pend_cls = 0; pend_data = '0; pend_src = '0;
      repeat (3) @(negedge clk);
      chk("R5 reset wr_en", 128'(wr_en), 128'(0));
      chk("R6 reset cls_we", 128'(cls_we), 128'(0));
      rst_n = 1'b1;

      cycle(1, 0, P_ONE,  N_TWO,  1, 1, 0, 5'b00000);   // clean pair
      cycle(1, 0, P_ONE,  SNAN,   1, 0, 1, 5'b00000);   // R4 lane 1 blocks only
      cycle(1, 0, SNAN,   P_ONE,  1, 0, 0, 5'b10000);   // R6 lane 0 blocks
      cycle(1, 0, SNAN,   SNAN,   0, 0, 0, 5'b00000);   // R4 disabled, still flags
      cycle(1, 0, QNAN,   N_QNAN, 1, 1, 0, 5'b00000);   // R1 quiet NaNs
      cycle(1, 0, N_ZERO, P_ONE,  0, 1, 0, 5'b00000);   // R2 negative zero blocks
      cycle(1, 0, P_ZERO, P_ONE,  1, 0, 0, 5'b00000);   // R2 zero, disabled
      cycle(1, 1, N_TWO,  P_ONE,  1, 0, 0, 5'b00000);   // R3 negative in sqrt
      cycle(1, 1, N_SNAN, N_ZERO, 0, 0, 0, 5'b00000);   // R3 snan/zero not negative
      cycle(1, 1, N_QNAN, N_DEN,  0, 0, 1, 5'b00000);   // R3 qnan and denormal
      cycle(1, 0, N_TWO,  N_DEN,  1, 1, 0, 5'b00000);   // R3 non-sqrt mode
      cycle(0, 1, SNAN,   P_ZERO, 1, 1, 1, 5'b01010);   // R8 idle
      cycle(1, 0, P_ONE,  P_ONE,  1, 1, 0, 5'b11111);   // R9 sticky kept, fi cleared
      cycle(0, 0, P_ONE,  P_ONE,  0, 0, 0, 5'b00000);

      for (int i = 0; i < 400; i++) begin
         cycle(($urandom % 4) != 0, $urandom % 2, pick($urandom), pick($urandom),
               $urandom % 2, $urandom % 2, $urandom % 2, 5'($urandom));
      end
      cycle(0, 0, P_ONE, P_ONE, 0, 0, 0, 5'b00000);
      @(negedge clk);
      chk_regs();

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule